// File: doc/BRIEF.md
# Round-Robin Contiguous Tag Merger

This block sits after a bank of W tag-ordered linear sorters that were loaded by spreading incoming entries across the bank by tag modulo W. Each sorter presents its smallest entry (tag and data) and a valid flag. The merger pulls entries out of the bank one at a time and rebuilds one stream in which the tags climb by exactly one per entry. The next tag it wants always lives in one sorter, the one whose index equals that tag modulo W. So each cycle it inspects only that sorter's head. It asks that sorter to drop its head only when the head carries the wanted tag. If the wanted tag has not arrived yet, the merger waits.

A start pulse loads the first wanted tag from `base_tag`. The merger then holds off until the bank reports that at least `accum_thresh` entries are stored. A flush level switches to draining mode. In that mode the contiguity test is dropped and the smallest head across the whole bank is taken each cycle. The output is a single registered entry with a valid/ready handshake. The bank is asked to delete a head only in a cycle where that entry can move into the output register.

Four named states form the controller. IDLE waits for `start`. ACCUM waits for the stored count to reach the threshold. STREAM performs contiguous merging. FLUSH drains in smallest-first order. The transitions are as follows:
- IDLE→ACCUM on start.
- ACCUM→STREAM when the count reaches the threshold.
- ACCUM→FLUSH and STREAM→FLUSH when flush is high; flush takes priority over the threshold.
- FLUSH→STREAM when flush falls.

Top module: `rr_merge_unit`

## Requirements
- R1: After reset the merger is in IDLE with `out_valid` low and `del_o` all zero, and it issues no delete until started.
- R2: A `start` pulse in IDLE loads `base_tag` as the wanted tag and enters ACCUM. In ACCUM no delete is issued until `stored_count >= accum_thresh` is seen, after which the merger enters STREAM on the next edge. Once in STREAM it does not go back to ACCUM.
- R3: In STREAM the only sorter examined is index `expected mod W` (the low log2(W) bits of the wanted tag). `del_o` bit of that index is raised in the same cycle exactly when that sorter is valid, its head tag equals the wanted tag and `out_ready` is high.
- R4: When the wanted sorter is empty or its head tag differs, no delete is issued and the merger keeps waiting. It resumes in the cycle the wanted tag becomes the head.
- R5: After each emitted entry the wanted tag becomes the emitted tag plus one, modulo 2^TAG_W, so tag 255 is followed by tag 0 for 8-bit tags.
- R6: An entry whose delete is raised in a cycle appears on `out_valid`/`out_tag`/`out_data` after the next clock edge. A cycle with `out_ready` high and no delete leaves `out_valid` low afterwards.
- R7: While `out_ready` is low no delete is issued and `out_valid`, `out_tag`, `out_data` stay unchanged.
- R8: In FLUSH the merger takes the valid head with the smallest tag across all sorters, regardless of the wanted tag, with the lowest sorter index winning a tie. The wanted tag becomes that tag plus one.
- R9: When `flush` falls, the merger returns to STREAM and continues contiguous merging from the wanted tag left by the last flushed entry.
- R10: `del_o` has at most one bit set and never targets a sorter whose valid flag is low.
- R11: A `start` pulse outside IDLE is ignored; the wanted tag and stream order are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse in IDLE to begin a run |
| base_tag | input | TAG_W | First wanted tag, loaded on start |
| accum_thresh | input | CNT_W | Stored-entry count needed before merging begins |
| stored_count | input | CNT_W | Number of entries currently held by the sorter bank |
| flush | input | 1 | Level: drain smallest-first without contiguity test |
| top_valid | input | W | Per-sorter head present flag |
| top_tag | input | W*TAG_W | Per-sorter head tag, sorter i at bits [i*TAG_W +: TAG_W] |
| top_data | input | W*DATA_W | Per-sorter head data, sorter i at bits [i*DATA_W +: DATA_W] |
| del_o | output | W | One-hot request to drop the head of a sorter |
| out_valid | output | 1 | Output entry present |
| out_tag | output | TAG_W | Output entry tag |
| out_data | output | DATA_W | Output entry data |
| out_ready | input | 1 | Consumer accepts the output entry this cycle |

## Verification
The delete request is combinational: it follows the head inputs, `out_ready` and the current state in the same cycle. The bench therefore drives inputs at the falling edge and samples `del_o` one nanosecond later, before the rising edge. The emitted entry, the state change after `start`, the threshold and `flush` all take one rising edge. The bench checks the output register at the next falling edge against a model that advanced on that same edge. Sorter heads drop only after the edge that consumed a delete, so the bench pops its model queues at the following falling edge.

// File: rtl/merge_pkg.sv
package merge_pkg;

    typedef enum logic [1:0] {
        MRG_IDLE   = 2'd0,
        MRG_ACCUM  = 2'd1,
        MRG_STREAM = 2'd2,
        MRG_FLUSH  = 2'd3
    } mrg_state_t;

endpackage

// File: rtl/merge_rr_probe.sv
module merge_rr_probe #(
    parameter int W     = 4,
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0]   expected,
    input  logic [W-1:0]       top_valid,
    input  logic [W*TAG_W-1:0] top_tag,
    output logic               hit,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    logic [TAG_W-1:0] head;

    // The wanted tag can only live in the sorter named by its low bits.
    assign idx  = expected[IW-1:0];
    assign head = top_tag[idx*TAG_W +: TAG_W];
    assign hit  = top_valid[idx] && (head == expected);

endmodule

// File: rtl/merge_min_pick.sv
module merge_min_pick #(
    parameter int W     = 4,
    parameter int TAG_W = 8
) (
    input  logic [W-1:0]         top_valid,
    input  logic [W*TAG_W-1:0]   top_tag,
    output logic                 any,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    logic             cv [W+1];
    logic [TAG_W-1:0] ct [W+1];
    logic [IW-1:0]    ci [W+1];

    assign cv[0] = 1'b0;
    assign ct[0] = '0;
    assign ci[0] = '0;

    // Linear chain: strict less-than keeps the lower index on equal tags.
    for (genvar g = 0; g < W; g++) begin : g_stage
        logic             better;
        logic [TAG_W-1:0] tg;
        assign tg       = top_tag[g*TAG_W +: TAG_W];
        assign better   = top_valid[g] && (!cv[g] || (tg < ct[g]));
        assign cv[g+1]  = cv[g] || top_valid[g];
        assign ct[g+1]  = better ? tg : ct[g];
        assign ci[g+1]  = better ? IW'(g) : ci[g];
    end

    assign any = cv[W];
    assign idx = ci[W];

endmodule

// File: rtl/merge_out_stage.sv
module merge_out_stage #(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              q_valid,
    output logic [TAG_W-1:0]  q_tag,
    output logic [DATA_W-1:0] q_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_data  <= '0;
        end else if (advance) begin
            q_valid <= load;
            if (load) begin
                q_tag  <= in_tag;
                q_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/rr_merge_unit.sv
module rr_merge_unit
    import merge_pkg::*;
#(
    parameter int W      = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TAG_W-1:0]    base_tag,
    input  logic [CNT_W-1:0]    accum_thresh,
    input  logic [CNT_W-1:0]    stored_count,
    input  logic                flush,
    input  logic [W-1:0]        top_valid,
    input  logic [W*TAG_W-1:0]  top_tag,
    input  logic [W*DATA_W-1:0] top_data,
    output logic [W-1:0]        del_o,
    output logic                out_valid,
    output logic [TAG_W-1:0]    out_tag,
    output logic [DATA_W-1:0]   out_data,
    input  logic                out_ready
);
    localparam int IW = $clog2(W);

    mrg_state_t       state_q, state_d;
    logic [TAG_W-1:0] expect_q;

    logic             rr_hit;
    logic [IW-1:0]    rr_idx;
    logic             mn_any;
    logic [IW-1:0]    mn_idx;

    logic             take;
    logic [IW-1:0]    sel;
    logic [TAG_W-1:0] sel_tag;
    logic [DATA_W-1:0] sel_data;

    merge_rr_probe #(.W(W), .TAG_W(TAG_W)) u_probe (
        .expected  (expect_q),
        .top_valid (top_valid),
        .top_tag   (top_tag),
        .hit       (rr_hit),
        .idx       (rr_idx)
    );

    merge_min_pick #(.W(W), .TAG_W(TAG_W)) u_minpick (
        .top_valid (top_valid),
        .top_tag   (top_tag),
        .any       (mn_any),
        .idx       (mn_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MRG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MRG_IDLE:   if (start) state_d = MRG_ACCUM;
            MRG_ACCUM: begin
                if (flush)                             state_d = MRG_FLUSH;
                else if (stored_count >= accum_thresh) state_d = MRG_STREAM;
            end
            MRG_STREAM: if (flush)  state_d = MRG_FLUSH;
            MRG_FLUSH:  if (!flush) state_d = MRG_STREAM;
        endcase
    end

    // Per-state outputs: which head is taken this cycle
    always_comb begin
        take = 1'b0;
        sel  = '0;
        unique case (state_q)
            MRG_IDLE, MRG_ACCUM: begin
                take = 1'b0;
                sel  = '0;
            end
            MRG_STREAM: begin
                take = rr_hit && out_ready;
                sel  = rr_idx;
            end
            MRG_FLUSH: begin
                take = mn_any && out_ready;
                sel  = mn_idx;
            end
        endcase
    end

    assign sel_tag  = top_tag[sel*TAG_W +: TAG_W];
    assign sel_data = top_data[sel*DATA_W +: DATA_W];
    assign del_o    = take ? ({{(W-1){1'b0}}, 1'b1} << sel) : '0;

    // Wanted tag: loaded on start, then one past whatever was emitted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            expect_q <= '0;
        else if (state_q == MRG_IDLE && start)
            expect_q <= base_tag;
        else if (take)
            expect_q <= sel_tag + 1'b1;
    end

    merge_out_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .advance (out_ready),
        .in_tag  (sel_tag),
        .in_data (sel_data),
        .q_valid (out_valid),
        .q_tag   (out_tag),
        .q_data  (out_data)
    );

endmodule

// File: rtl/rr_merge_unit_chk.sv
module rr_merge_unit_chk #(
    parameter int W      = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      top_valid,
    input logic [W-1:0]      del_o,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_tag,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready
);

    // R10
    del_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(del_o));

    // R10
    del_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (del_o & ~top_valid) == '0);

    // R7
    no_del_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> del_o == '0);

    // R7
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)));

    // R6
    del_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (del_o != '0) |=> out_valid);

    // R6
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && del_o == '0) |=> !out_valid);

endmodule

bind rr_merge_unit rr_merge_unit_chk #(.W(W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_valid (top_valid),
    .del_o     (del_o),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/rr_merge_unit_bench.sv
`timescale 1ns/1ps
module rr_merge_unit_bench;
    localparam int W = 4, TW = 8, DW = 8, CW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, flush = 0, out_ready = 0;
    logic [TW-1:0] base_tag = '0;
    logic [CW-1:0] accum_thresh = '0, stored_count = '0;
    logic [W-1:0]  top_valid = '0;
    logic [W*TW-1:0] top_tag = '0;
    logic [W*DW-1:0] top_data = '0;
    logic [W-1:0]  del_o;
    logic          out_valid;
    logic [TW-1:0] out_tag;
    logic [DW-1:0] out_data;

    always #2 clk = ~clk;

    rr_merge_unit #(.W(W), .TAG_W(TW), .DATA_W(DW), .CNT_W(CW)) u_rr_merge_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .base_tag(base_tag),
        .accum_thresh(accum_thresh), .stored_count(stored_count), .flush(flush),
        .top_valid(top_valid), .top_tag(top_tag), .top_data(top_data),
        .del_o(del_o), .out_valid(out_valid), .out_tag(out_tag),
        .out_data(out_data), .out_ready(out_ready)
    );

    int checks = 0, fails = 0;
    string phase = "R1";

    // Sorter bank model: ordered queues of tags and data.
    int qt [W][$];
    int qd [W][$];

    // Merger model: 0 idle, 1 accum, 2 stream, 3 flush
    int ms = 0, mexp = 0, mot = 0, mod_ = 0;
    bit mov = 0;
    int nms = 0, nexp = 0, nt = 0, nd = 0;
    bit nov = 0;
    int pend_pop = -1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", rq, phase, act, exp_v);
        end
    endtask

    task automatic step(input bit st, input bit fl, input bit rdy, input int ins_s, input int ins_t);
        int esel, edel, total, p, best, d;
        bit etake;
        @(negedge clk);
        if (pend_pop >= 0) begin
            void'(qt[pend_pop].pop_front());
            void'(qd[pend_pop].pop_front());
            pend_pop = -1;
        end
        ms = nms; mexp = nexp; mov = nov; mot = nt; mod_ = nd;
        // registered output, due one edge after the delete (R6)
        chk(out_valid == mov, "R6", out_valid, mov);
        if (mov) begin
            chk(out_tag == mot[7:0], "R6", out_tag, mot);
            chk(out_data == mod_[7:0], "R6", out_data, mod_);
        end
        if (ins_s >= 0) begin
            d = (ins_t ^ (ins_s * 37 + 11)) & 255;
            p = 0;
            while (p < qt[ins_s].size() && qt[ins_s][p] <= ins_t) p++;
            qt[ins_s].insert(p, ins_t);
            qd[ins_s].insert(p, d);
        end
        start = st; flush = fl; out_ready = rdy;
        total = 0;
        for (int i = 0; i < W; i++) begin
            total += qt[i].size();
            top_valid[i] = qt[i].size() > 0;
            top_tag[i*TW +: TW]  = (qt[i].size() > 0) ? qt[i][0][7:0] : 8'd0;
            top_data[i*DW +: DW] = (qt[i].size() > 0) ? qd[i][0][7:0] : 8'd0;
        end
        stored_count = total[CW-1:0];
        #1;
        etake = 0; esel = 0;
        if (ms == 2) begin
            esel = mexp % W;
            if (qt[esel].size() > 0 && qt[esel][0] == mexp && rdy) etake = 1;
        end else if (ms == 3) begin
            best = -1;
            for (int i = 0; i < W; i++)
                if (qt[i].size() > 0 && (best < 0 || qt[i][0] < qt[best][0])) best = i;
            if (best >= 0 && rdy) begin etake = 1; esel = best; end
        end
        edel = etake ? (1 << esel) : 0;
        // combinational delete (R3 stream, R8 flush, R10 shape)
        chk(del_o == edel[W-1:0], (ms == 3) ? "R8" : (ms == 2) ? "R3" : "R2", del_o, edel);
        chk($countones(del_o) <= 1, "R10", del_o, edel);
        nov = rdy ? etake : mov;
        nt = mot; nd = mod_;
        if (rdy && etake) begin nt = qt[esel][0]; nd = qd[esel][0]; end
        nexp = mexp;
        if (ms == 0 && st) nexp = base_tag;
        else if (etake) nexp = (qt[esel][0] + 1) % 256;
        case (ms)
            0: nms = st ? 1 : 0;
            1: nms = fl ? 3 : ((total >= accum_thresh) ? 2 : 1);
            2: nms = fl ? 3 : 2;
            default: nms = fl ? 3 : 2;
        endcase
        if (etake) pend_pop = esel;
    endtask

    task automatic idle(input int n, input bit fl);
        for (int k = 0; k < n; k++) step(0, fl, 1, -1, 0);
    endtask

    task automatic ins(input int t);
        step(0, 0, 1, t % W, t);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // R1: reset holds outputs quiet
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(del_o == '0, "R1", del_o, 0);
        rst_n = 1'b1;
        idle(2, 0);

        // R2: start, accumulate six entries, then stream 4..9
        phase = "R2";
        base_tag = 8'd4; accum_thresh = 6'd6;
        step(1, 0, 1, -1, 0);
        ins(7); ins(5); ins(6); ins(9); ins(4); ins(8);
        idle(8, 0);

        // R4: wanted tag 10 missing; 11 arrives first
        phase = "R4";
        ins(11); idle(3, 0);
        ins(10); idle(4, 0);

        // R7: consumer stalls
        phase = "R7";
        ins(12); ins(13); ins(14);
        step(0, 0, 0, -1, 0); step(0, 0, 0, -1, 0); step(0, 0, 1, -1, 0);
        step(0, 0, 0, -1, 0); step(0, 0, 1, -1, 0); step(0, 0, 0, -1, 0);
        idle(4, 0);

        // R11: start outside IDLE is ignored
        phase = "R11";
        base_tag = 8'd0;
        step(1, 0, 1, -1, 0);
        ins(15); idle(3, 0);

        // R8: flush drains smallest-first, then tie on tag 40
        phase = "R8";
        ins(20); ins(17); ins(30); ins(22);
        idle(2, 0);
        idle(6, 1);
        step(0, 1, 0, 1, 40);
        step(0, 1, 0, 2, 40);
        idle(4, 1);

        // R9: leave flush, contiguous again from 41
        phase = "R9";
        step(0, 0, 1, 1, 41);
        ins(42); ins(44); idle(3, 0);
        ins(43); idle(4, 0);

        // R5: wrap 255 -> 0
        phase = "R5";
        step(0, 1, 1, 2, 254);
        idle(3, 1);
        step(0, 0, 1, 0, 0);
        idle(2, 0);
        ins(255);
        idle(5, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule